// File: doc/BRIEF.md
# Write-Back Write-Allocate Second-Level Cache with Victim Buffer

This block is a direct-mapped second-level cache placed between an upper cache level and main memory. The upper level sends whole-block requests: reads, and writes with per-byte strobes. Hits are served from the line array. A write hit updates the line and marks it dirty, and causes no memory traffic. Any miss allocates a line, so a write miss first brings the block in from memory and then merges the strobed bytes into it.

When a miss has to replace a dirty line, the victim is parked in a one-entry buffer. The fill read for the missing block goes out first, and the parked victim is written to memory only after the fill data has arrived. This lets the requester see the new block without waiting for the eviction. While the victim sits in the buffer, reads to that block are answered from the buffer. A write to that block waits until the buffer has drained. A second dirty eviction also waits until the buffer has drained. The block talks to memory over two channels: a fill-read request with a returning data strobe, and a writeback channel with a valid/ready handshake.

Top module: `l2wb_cache`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `req_ready` is 1 and `rsp_valid`, `mem_rd_valid` and `mem_wb_valid` are 0. All lines start invalid.
- R2: A read that hits returns the stored block with `rsp_hit`=1. `rsp_valid` rises on the second clock edge after the request is accepted, and there is no memory traffic.
- R3: A write hit replaces exactly the bytes whose `req_wstrb` bit is 1 (bit i selects bits 8i+7..8i of the block). It marks the line dirty and responds with the merged block and `rsp_hit`=1. It causes no fill and no writeback.
- R4: A write miss fetches the block from memory, merges the strobed bytes into it, stores the result as a dirty line, and responds with the merged block and `rsp_hit`=0.
- R5: A miss whose victim line is invalid or clean issues exactly one fill and no writeback. A read miss responds with the memory block and `rsp_hit`=0.
- R6: A miss whose victim line is dirty writes that victim exactly once, with its own block address and its latest contents, on the writeback channel.
- R7: The fill request for the new block goes out before the dirty victim is offered. `mem_wb_valid` rises only in the cycle after `mem_fill_valid` was high.
- R8: A read to the block held in the victim buffer is answered from the buffer: current contents, `rsp_hit`=1, same latency as a hit, no fill.
- R9: A write to the block held in the victim buffer stalls until its writeback completes. It is then handled as a miss that fetches the updated block from memory. A fill is never requested for the block being written back.
- R10: A miss that needs to evict a dirty line while the victim buffer is occupied issues no fill until the buffer has drained. It then completes normally.
- R11: The set index is the low log2(SETS) bits of the block address and the tag is the remaining bits. `mem_rd_addr` equals the requested block address.
- R12: `mem_rd_valid` stays high with a stable address until `mem_rd_ready`. `mem_wb_valid` stays high with stable address and data until `mem_wb_ready`.
- R13: Only one request is in flight at a time. `req_ready` is 0 from acceptance until the response, and `rsp_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upper-level request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Block address |
| req_wdata | input | BLOCK_BYTES*8 | Write data block |
| req_wstrb | input | BLOCK_BYTES | Per-byte write enables |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 when served without a fill |
| rsp_rdata | output | BLOCK_BYTES*8 | Block contents after the access |
| mem_rd_valid | output | 1 | Fill read request |
| mem_rd_ready | input | 1 | Memory accepts fill request |
| mem_rd_addr | output | ADDR_W | Block address to fill |
| mem_fill_valid | input | 1 | Fill data present |
| mem_fill_data | input | BLOCK_BYTES*8 | Fill data block |
| mem_wb_valid | output | 1 | Victim writeback offered |
| mem_wb_ready | input | 1 | Memory accepts writeback |
| mem_wb_addr | output | ADDR_W | Victim block address |
| mem_wb_data | output | BLOCK_BYTES*8 | Victim block contents |

## Verification
Each scenario is a directed task, and each task predicts data and memory traffic from a shadow copy of memory. The bench walks through cold read misses, read hits, strobed write hits and write misses, which tell apart whether a fill happened and whether bytes were merged correctly. Conflicting addresses in one set separate clean replacement from dirty replacement, and the relative cycles of fill and writeback expose the ordering. The writeback channel is held off to keep a victim parked. Reads and writes to the parked block, and a second dirty miss, then distinguish forwarding from the buffer, stalling on a write, and stalling on a full buffer.

// File: rtl/l2wb_pkg.sv
package l2wb_pkg;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_LOOKUP,
        MS_EVICT,
        MS_FILL,
        MS_FWAIT,
        MS_RESPOND
    } miss_state_e;

    typedef enum logic [1:0] {
        VB_EMPTY,
        VB_PARKED,
        VB_DRAIN
    } vb_state_e;

    localparam int unsigned DEF_BLOCK_BYTES = 64;
    localparam int unsigned DEF_ADDR_W      = 8;
    localparam int unsigned DEF_SETS        = 8;

endpackage

// File: rtl/l2wb_byte_merge.sv
module l2wb_byte_merge #(
    parameter int unsigned BYTES = 64
) (
    input  logic [BYTES*8-1:0] base,
    input  logic [BYTES*8-1:0] upd,
    input  logic [BYTES-1:0]   strb,
    output logic [BYTES*8-1:0] merged
);
    genvar g;
    generate
        for (g = 0; g < BYTES; g++) begin : g_byte
            assign merged[g*8 +: 8] = strb[g] ? upd[g*8 +: 8] : base[g*8 +: 8];
        end
    endgenerate
endmodule

// File: rtl/l2wb_line_store.sv
module l2wb_line_store #(
    parameter int unsigned SETS  = 8,
    parameter int unsigned TAG_W = 5,
    parameter int unsigned BLK_W = 512,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic [BLK_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dirty,
    input  logic [BLK_W-1:0] wr_data
);
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [TAG_W-1:0] tag_q  [SETS];
    logic [BLK_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/l2wb_victim_buf.sv
module l2wb_victim_buf
    import l2wb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned BLK_W  = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [BLK_W-1:0]  load_data,
    input  logic              arm,
    output logic              occupied,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_match,
    output logic [BLK_W-1:0]  held_data,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [BLK_W-1:0]  wb_data
);
    vb_state_e         st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BLK_W-1:0]  data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= VB_EMPTY;
        end else begin
            case (st_q)
                VB_EMPTY:  if (load) st_q <= VB_PARKED;
                VB_PARKED: if (arm) st_q <= VB_DRAIN;
                VB_DRAIN:  if (wb_ready) st_q <= VB_EMPTY;
                default:   st_q <= VB_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (load && st_q == VB_EMPTY) begin
            addr_q <= load_addr;
            data_q <= load_data;
        end
    end

    assign occupied    = (st_q != VB_EMPTY);
    assign probe_match = occupied && (addr_q == probe_addr);
    assign held_data   = data_q;
    assign wb_valid    = (st_q == VB_DRAIN);
    assign wb_addr     = addr_q;
    assign wb_data     = data_q;
endmodule

// File: rtl/l2wb_miss_ctrl.sv
module l2wb_miss_ctrl
    import l2wb_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SETS        = 8,
    parameter int unsigned BLOCK_BYTES = 64,
    localparam int unsigned BLK_W = BLOCK_BYTES * 8,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BLK_W-1:0]  req_wdata,
    input  logic [BLOCK_BYTES-1:0] req_wstrb,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [BLK_W-1:0]  rsp_rdata,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_fill_valid,
    input  logic [BLK_W-1:0]  mem_fill_data,
    output logic [IDX_W-1:0]  ls_idx,
    input  logic              ls_valid,
    input  logic              ls_dirty,
    input  logic [TAG_W-1:0]  ls_tag,
    input  logic [BLK_W-1:0]  ls_data,
    output logic              ls_wr_en,
    output logic [TAG_W-1:0]  ls_wr_tag,
    output logic              ls_wr_dirty,
    output logic [BLK_W-1:0]  ls_wr_data,
    output logic              vb_load,
    output logic [ADDR_W-1:0] vb_load_addr,
    output logic [BLK_W-1:0]  vb_load_data,
    output logic              vb_arm,
    input  logic              vb_occupied,
    input  logic              vb_match,
    input  logic [BLK_W-1:0]  vb_data,
    output logic [ADDR_W-1:0] vb_probe_addr
);
    miss_state_e            st_q, st_d;
    logic                   q_write;
    logic [ADDR_W-1:0]      q_addr;
    logic [BLK_W-1:0]       q_wdata;
    logic [BLOCK_BYTES-1:0] q_wstrb;
    logic [BLK_W-1:0]       rsp_data_q, rsp_data_d;
    logic                   rsp_hit_q, rsp_hit_d, rsp_load;
    logic [BLK_W-1:0]       hit_merged, fill_merged;
    logic [TAG_W-1:0]       q_tag;
    logic                   tag_hit, victim_dirty;

    assign ls_idx        = q_addr[IDX_W-1:0];
    assign q_tag         = q_addr[ADDR_W-1:IDX_W];
    assign tag_hit       = ls_valid && (ls_tag == q_tag);
    assign victim_dirty  = ls_valid && ls_dirty;
    assign vb_probe_addr = q_addr;
    assign vb_load_addr  = {ls_tag, ls_idx};
    assign vb_load_data  = ls_data;
    assign mem_rd_addr   = q_addr;

    l2wb_byte_merge #(.BYTES(BLOCK_BYTES)) hit_merge_i (
        .base(ls_data), .upd(q_wdata), .strb(q_wstrb), .merged(hit_merged)
    );
    l2wb_byte_merge #(.BYTES(BLOCK_BYTES)) fill_merge_i (
        .base(mem_fill_data), .upd(q_wdata), .strb(q_wstrb), .merged(fill_merged)
    );

    always_comb begin
        st_d         = st_q;
        req_ready    = (st_q == MS_IDLE);
        rsp_valid    = (st_q == MS_RESPOND);
        mem_rd_valid = 1'b0;
        ls_wr_en     = 1'b0;
        ls_wr_tag    = q_tag;
        ls_wr_dirty  = 1'b0;
        ls_wr_data   = ls_data;
        vb_load      = 1'b0;
        vb_arm       = 1'b0;
        rsp_load     = 1'b0;
        rsp_data_d   = ls_data;
        rsp_hit_d    = 1'b0;
        case (st_q)
            MS_IDLE: begin
                if (req_valid) st_d = MS_LOOKUP;
            end
            MS_LOOKUP: begin
                if (vb_match) begin
                    if (!q_write) begin
                        rsp_load   = 1'b1;
                        rsp_data_d = vb_data;
                        rsp_hit_d  = 1'b1;
                        st_d       = MS_RESPOND;
                    end
                end else if (tag_hit) begin
                    rsp_load  = 1'b1;
                    rsp_hit_d = 1'b1;
                    st_d      = MS_RESPOND;
                    if (q_write) begin
                        ls_wr_en    = 1'b1;
                        ls_wr_dirty = 1'b1;
                        ls_wr_data  = hit_merged;
                        rsp_data_d  = hit_merged;
                    end
                end else if (victim_dirty) begin
                    if (!vb_occupied) st_d = MS_EVICT;
                end else begin
                    st_d = MS_FILL;
                end
            end
            MS_EVICT: begin
                vb_load = 1'b1;
                st_d    = MS_FILL;
            end
            MS_FILL: begin
                mem_rd_valid = 1'b1;
                if (mem_rd_ready) st_d = MS_FWAIT;
            end
            MS_FWAIT: begin
                if (mem_fill_valid) begin
                    ls_wr_en    = 1'b1;
                    ls_wr_dirty = q_write;
                    ls_wr_data  = q_write ? fill_merged : mem_fill_data;
                    rsp_load    = 1'b1;
                    rsp_data_d  = q_write ? fill_merged : mem_fill_data;
                    vb_arm      = 1'b1;
                    st_d        = MS_RESPOND;
                end
            end
            MS_RESPOND: begin
                st_d = MS_IDLE;
            end
            default: st_d = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= MS_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (st_q == MS_IDLE && req_valid) begin
            q_write <= req_write;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
            q_wstrb <= req_wstrb;
        end
        if (rsp_load) begin
            rsp_data_q <= rsp_data_d;
            rsp_hit_q  <= rsp_hit_d;
        end
    end

    assign rsp_rdata = rsp_data_q;
    assign rsp_hit   = rsp_hit_q;
endmodule

// File: rtl/l2wb_cache.sv
module l2wb_cache
    import l2wb_pkg::*;
#(
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    parameter int unsigned SETS        = DEF_SETS,
    parameter int unsigned BLOCK_BYTES = DEF_BLOCK_BYTES,
    localparam int unsigned BLK_W = BLOCK_BYTES * 8,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [BLK_W-1:0]       req_wdata,
    input  logic [BLOCK_BYTES-1:0] req_wstrb,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [BLK_W-1:0]       rsp_rdata,
    output logic                   mem_rd_valid,
    input  logic                   mem_rd_ready,
    output logic [ADDR_W-1:0]      mem_rd_addr,
    input  logic                   mem_fill_valid,
    input  logic [BLK_W-1:0]       mem_fill_data,
    output logic                   mem_wb_valid,
    input  logic                   mem_wb_ready,
    output logic [ADDR_W-1:0]      mem_wb_addr,
    output logic [BLK_W-1:0]       mem_wb_data
);
    logic [IDX_W-1:0]  ls_idx;
    logic              ls_valid, ls_dirty, ls_wr_en, ls_wr_dirty;
    logic [TAG_W-1:0]  ls_tag, ls_wr_tag;
    logic [BLK_W-1:0]  ls_data, ls_wr_data;
    logic              vb_load, vb_arm, vb_occupied, vb_match;
    logic [ADDR_W-1:0] vb_load_addr, vb_probe_addr;
    logic [BLK_W-1:0]  vb_load_data, vb_data;

    l2wb_line_store #(.SETS(SETS), .TAG_W(TAG_W), .BLK_W(BLK_W)) lines_i (
        .clk(clk), .rst(rst),
        .rd_idx(ls_idx), .rd_valid(ls_valid), .rd_dirty(ls_dirty),
        .rd_tag(ls_tag), .rd_data(ls_data),
        .wr_en(ls_wr_en), .wr_idx(ls_idx), .wr_tag(ls_wr_tag),
        .wr_dirty(ls_wr_dirty), .wr_data(ls_wr_data)
    );

    l2wb_victim_buf #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) vbuf_i (
        .clk(clk), .rst(rst),
        .load(vb_load), .load_addr(vb_load_addr), .load_data(vb_load_data),
        .arm(vb_arm), .occupied(vb_occupied),
        .probe_addr(vb_probe_addr), .probe_match(vb_match), .held_data(vb_data),
        .wb_valid(mem_wb_valid), .wb_ready(mem_wb_ready),
        .wb_addr(mem_wb_addr), .wb_data(mem_wb_data)
    );

    l2wb_miss_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .BLOCK_BYTES(BLOCK_BYTES)) ctrl_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wstrb(req_wstrb),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
        .ls_idx(ls_idx), .ls_valid(ls_valid), .ls_dirty(ls_dirty),
        .ls_tag(ls_tag), .ls_data(ls_data),
        .ls_wr_en(ls_wr_en), .ls_wr_tag(ls_wr_tag), .ls_wr_dirty(ls_wr_dirty),
        .ls_wr_data(ls_wr_data),
        .vb_load(vb_load), .vb_load_addr(vb_load_addr), .vb_load_data(vb_load_data),
        .vb_arm(vb_arm), .vb_occupied(vb_occupied), .vb_match(vb_match),
        .vb_data(vb_data), .vb_probe_addr(vb_probe_addr)
    );
endmodule

// File: rtl/l2wb_cache_chk.sv
module l2wb_cache_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned BLK_W  = 512
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_fill_valid,
    input logic              mem_wb_valid,
    input logic              mem_wb_ready,
    input logic [ADDR_W-1:0] mem_wb_addr,
    input logic [BLK_W-1:0]  mem_wb_data
);
    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid && !mem_rd_valid && !mem_wb_valid));

    // R7
    fill_before_wb_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wb_valid) |-> $past(mem_fill_valid));

    // R9
    no_fill_of_victim_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && mem_wb_valid) |-> (mem_rd_addr != mem_wb_addr));

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R12
    wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wb_valid && !mem_wb_ready) |=>
            (mem_wb_valid && $stable(mem_wb_addr) && $stable(mem_wb_data)));

    // R13
    one_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R13
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind l2wb_cache l2wb_cache_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_fill_valid(mem_fill_valid),
    .mem_wb_valid(mem_wb_valid), .mem_wb_ready(mem_wb_ready),
    .mem_wb_addr(mem_wb_addr), .mem_wb_data(mem_wb_data)
);

// File: tb/l2wb_cache_tb_top.sv
module l2wb_cache_tb_top;
    localparam int AW = 8;
    localparam int NB = 64;
    localparam int BW = NB * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_wdata = '0;
    logic [NB-1:0] req_wstrb = '0;
    logic          req_ready, rsp_valid, rsp_hit;
    logic [BW-1:0] rsp_rdata;
    logic          mem_rd_valid, mem_wb_valid;
    logic          mem_rd_ready = 1'b1;
    logic [AW-1:0] mem_rd_addr, mem_wb_addr;
    logic          mem_fill_valid = 1'b0;
    logic [BW-1:0] mem_fill_data = '0;
    logic [BW-1:0] mem_wb_data;
    logic          mem_wb_ready;
    logic          wb_hold = 1'b0;

    assign mem_wb_ready = !wb_hold;
    always #5 clk = ~clk;

    l2wb_cache dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_wstrb(req_wstrb), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_rdata(rsp_rdata), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_fill_valid(mem_fill_valid),
        .mem_fill_data(mem_fill_data), .mem_wb_valid(mem_wb_valid),
        .mem_wb_ready(mem_wb_ready), .mem_wb_addr(mem_wb_addr), .mem_wb_data(mem_wb_data)
    );

    logic [BW-1:0] memm [256];
    logic [BW-1:0] gold [256];
    int n_chk = 0, n_fail = 0;
    int n_fill = 0, n_wb = 0, cyc = 0, fill_cyc = 0, wb_cyc = 0, fill_cnt = 0;
    logic [AW-1:0] fill_addr = '0, last_fill_addr = '0, last_wb_addr = '0;

    function automatic logic [BW-1:0] pat(input int a, input int salt);
        logic [BW-1:0] r;
        for (int i = 0; i < NB; i++) r[i*8 +: 8] = 8'((a * 7) + (i * 13) + salt);
        return r;
    endfunction

    function automatic logic [BW-1:0] mrg(input logic [BW-1:0] o, input logic [BW-1:0] n,
                                          input logic [NB-1:0] s);
        logic [BW-1:0] r;
        for (int i = 0; i < NB; i++) r[i*8 +: 8] = s[i] ? n[i*8 +: 8] : o[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string rq, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // memory model, sampled away from the rising edge
    always begin
        @(negedge clk);
        #1;
        cyc++;
        mem_fill_valid = 1'b0;
        if (fill_cnt != 0) begin
            fill_cnt--;
            if (fill_cnt == 0) begin
                mem_fill_valid = 1'b1;
                mem_fill_data  = memm[fill_addr];
            end
        end
        if (mem_rd_valid && mem_rd_ready) begin
            fill_cnt = 3; fill_addr = mem_rd_addr; last_fill_addr = mem_rd_addr;
            n_fill++; fill_cyc = cyc;
        end
        if (mem_wb_valid && mem_wb_ready) begin
            chk("R6 wb data", mem_wb_data, gold[mem_wb_addr]);
            memm[mem_wb_addr] = mem_wb_data;
            last_wb_addr = mem_wb_addr;
            n_wb++; wb_cyc = cyc;
        end
    end

    task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [BW-1:0] wd,
                          input logic [NB-1:0] st, output logic [BW-1:0] rd,
                          output bit hit, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_wstrb = st;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 2000) begin @(negedge clk); lat++; end
        if (lat >= 2000) chk("R13 response timeout", 0, 1);
        rd = rsp_rdata; hit = rsp_hit;
        if (wr) gold[a] = mrg(gold[a], wd, st);
    endtask

    task automatic t_reset();
        chk("R1 req_ready", req_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rd_valid", mem_rd_valid, 0);
        chk("R1 wb_valid", mem_wb_valid, 0);
    endtask

    task automatic t_read_miss_clean();
        logic [BW-1:0] rd; bit h; int l; int f0 = n_fill; int w0 = n_wb;
        do_req(0, 8'h05, '0, '0, rd, h, l);
        chk("R5 read miss data", rd, gold[8'h05]);
        chk("R5 miss flag", h, 0);
        chk("R5 one fill", n_fill - f0, 1);
        chk("R11 fill address", last_fill_addr, 8'h05);
        repeat (4) @(negedge clk);
        chk("R5 no writeback", n_wb - w0, 0);
    endtask

    task automatic t_read_hit();
        logic [BW-1:0] rd; bit h; int l; int f0 = n_fill; int w0 = n_wb;
        do_req(0, 8'h05, '0, '0, rd, h, l);
        chk("R2 hit data", rd, gold[8'h05]);
        chk("R2 hit flag", h, 1);
        chk("R2 hit latency", l, 1);
        chk("R2 no traffic", (n_fill - f0) + (n_wb - w0), 0);
    endtask

    task automatic t_write_hit();
        logic [BW-1:0] rd, exp; bit h; int l; int f0 = n_fill; int w0 = n_wb;
        logic [BW-1:0] wd = pat(200, 99);
        exp = mrg(gold[8'h05], wd, 64'h0000_0000_0000_F00F);
        do_req(1, 8'h05, wd, 64'h0000_0000_0000_F00F, rd, h, l);
        chk("R3 merged data", rd, exp);
        chk("R3 hit flag", h, 1);
        do_req(0, 8'h05, '0, '0, rd, h, l);
        chk("R3 readback", rd, exp);
        chk("R3 no traffic", (n_fill - f0) + (n_wb - w0), 0);
    endtask

    task automatic t_write_miss();
        logic [BW-1:0] rd, exp; bit h; int l; int f0 = n_fill;
        logic [BW-1:0] wd = pat(17, 55);
        exp = mrg(memm[8'h12], wd, 64'hFF00_0000_0000_00F0);
        do_req(1, 8'h12, wd, 64'hFF00_0000_0000_00F0, rd, h, l);
        chk("R4 merged fill", rd, exp);
        chk("R4 miss flag", h, 0);
        chk("R4 one fill", n_fill - f0, 1);
        do_req(0, 8'h12, '0, '0, rd, h, l);
        chk("R4 readback hit", {rd[BW-2:0], h}, {exp[BW-2:0], 1'b1});
    endtask

    task automatic t_dirty_evict();
        logic [BW-1:0] rd; bit h; int l; int w0 = n_wb; int f0 = n_fill;
        do_req(0, 8'h0D, '0, '0, rd, h, l);
        repeat (6) @(negedge clk);
        chk("R5 conflict data", rd, gold[8'h0D]);
        chk("R6 one writeback", n_wb - w0, 1);
        chk("R6 victim address", last_wb_addr, 8'h05);
        chk("R7 fill before wb", wb_cyc > fill_cyc, 1);
        w0 = n_wb;
        do_req(0, 8'h05, '0, '0, rd, h, l);
        repeat (6) @(negedge clk);
        chk("R6 refetched victim", rd, gold[8'h05]);
        chk("R5 clean victim no wb", n_wb - w0, 0);
        chk("R11 fills", n_fill - f0, 2);
    endtask

    task automatic t_victim_buffer();
        logic [BW-1:0] rd, exp; bit h; int l; int f0, w0;
        logic [BW-1:0] wd = pat(3, 77);
        do_req(1, 8'h03, wd, {NB{1'b1}}, rd, h, l);
        wb_hold = 1'b1;
        do_req(0, 8'h0B, '0, '0, rd, h, l);
        f0 = n_fill; w0 = n_wb;
        do_req(0, 8'h03, '0, '0, rd, h, l);
        chk("R8 buffer data", rd, gold[8'h03]);
        chk("R8 hit flag", h, 1);
        chk("R8 latency", l, 1);
        chk("R8 no fill", n_fill - f0, 0);
        exp = mrg(gold[8'h03], pat(9, 1), 64'h0F);
        fork
            do_req(1, 8'h03, pat(9, 1), 64'h0F, rd, h, l);
            begin
                repeat (15) @(negedge clk);
                chk("R9 no fill while held", n_fill - f0, 0);
                chk("R12 wb held", {mem_wb_valid, mem_wb_addr}, {1'b1, 8'h03});
                wb_hold = 1'b0;
            end
        join
        chk("R9 write stalled", l > 15, 1);
        chk("R9 wb count", n_wb - w0, 1);
        chk("R9 fill after wb", fill_cyc > wb_cyc, 1);
        chk("R9 merged data", rd, exp);
    endtask

    task automatic t_full_buffer_stall();
        logic [BW-1:0] rd; bit h; int l; int f0, w0;
        do_req(1, 8'h21, pat(33, 4), {NB{1'b1}}, rd, h, l);
        do_req(1, 8'h26, pat(38, 8), 64'hFFFF, rd, h, l);
        wb_hold = 1'b1;
        do_req(0, 8'h29, '0, '0, rd, h, l);
        f0 = n_fill; w0 = n_wb;
        fork
            do_req(0, 8'h2E, '0, '0, rd, h, l);
            begin
                repeat (15) @(negedge clk);
                chk("R10 no fill while full", n_fill - f0, 0);
                wb_hold = 1'b0;
            end
        join
        repeat (8) @(negedge clk);
        chk("R10 stalled", l > 15, 1);
        chk("R10 data", rd, gold[8'h2E]);
        chk("R10 two writebacks", n_wb - w0, 2);
        chk("R10 last victim", last_wb_addr, 8'h26);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) begin memm[a] = pat(a, 0); gold[a] = memm[a]; end
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_miss_clean();
        t_read_hit();
        t_write_hit();
        t_write_miss();
        t_dirty_evict();
        t_victim_buffer();
        t_full_buffer_stall();
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule